// File: doc/BRIEF.md
# SPI Transfer Word Counter With Automatic Reload

This block sets the length of bursts on the receive and transmit channels of a SPI master. Each channel keeps a count of the words still to be moved. The count goes down by one for every word the shift engine reports as complete, but only while that channel's counter is enabled. When a burst ends, the counter reloads itself from a per-channel reload value, so back-to-back bursts run without software stepping in. A reload value of zero turns this off, and the counter then parks at zero.

The end of a burst sets a sticky finish flag for that channel. Software clears the flag by writing a one to it. On the transmit side, an optional stall output tells the shift engine not to start a new word while the transmit FIFO is empty. Registers are written through a single write strobe with a 3-bit register select and a 16-bit data word. The current counts and the flags are brought out as plain outputs.

Top module: `spi_word_count_ctl`

## Requirements
- R1: Synchronous active-low reset clears both counts, both reload values, both counter enables, both finish flags and the stall option, so every output reads 0 after reset.
- R2: A write with select 0 (receive) or 3 (transmit) loads wr_data into that channel's count on the next edge, whether or not the counter is enabled. When it meets a word-complete pulse in the same cycle, the write wins.
- R3: The count falls by one on each clock edge where the channel's enable bit is set and its word-complete input is high. Select 2 (receive) or 5 (transmit) writes the enable from wr_data bit 0. While the counter is disabled, the count holds.
- R4: A decrement from 1 loads the count with the channel's reload value on that same edge, instead of passing through 0.
- R5: When the reload value is 0, a decrement from 1 leaves the count at 0. A word-complete pulse at count 0 leaves it at 0, with no wrap to the all-ones value.
- R6: A write to the reload value (select 1 receive, select 4 transmit) takes effect only while that channel's counter is disabled. While the counter is enabled the write is ignored.
- R7: The finish flag of a channel is set on the same edge as that channel's decrement from 1. It stays set until it is cleared. If a set and a clear fall in the same cycle, the set wins.
- R8: A write with select 6 clears the receive finish flag where wr_data bit 0 is 1, and the transmit finish flag where wr_data bit 1 is 1. A zero in a bit leaves that flag as it is.
- R9: Select 7 writes the transmit stall option from wr_data bit 0. tx_stall is high exactly when the option is set and tx_fifo_empty is high, with no clock delay from tx_fifo_empty.
- R10: Events on one channel (its word-complete pulse, its register writes) leave the other channel's count and finish flag unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select (codes are given in the requirements) |
| wr_data | input | 16 | Write data |
| rx_word_done | input | 1 | One-cycle pulse per completed received word |
| tx_word_done | input | 1 | One-cycle pulse per completed transmitted word |
| tx_fifo_empty | input | 1 | Transmit FIFO is empty |
| rx_count | output | 16 | Words left in the receive burst |
| tx_count | output | 16 | Words left in the transmit burst |
| rx_finish | output | 1 | Receive finish flag (sticky) |
| tx_finish | output | 1 | Transmit finish flag (sticky) |
| tx_stall | output | 1 | Hold off new transmit words |

## Verification
The bench reaches the end of a burst with a nonzero reload value and with a zero one. A design that passed through zero before reloading, or that wrapped to 0xFFFF, would show the wrong count right after that edge. The bench writes a new reload value while the counter runs and then checks that the old value comes back at the end of the burst. It also lines up a count write against a word-complete pulse, and a finish clear against a finish set, in the same cycle. A design with either priority reversed would leave a decremented count or a lost flag. A zero-bit clear write and a word pulse on one channel are each checked against the other outputs, which catches flags cleared by mistake and crosstalk between the channels.

// File: rtl/spi_wc_pkg.sv
// Shared constants for the SPI word counter block.
// Assumes exactly two channels: index 0 is receive, index 1 is transmit.
package spi_wc_pkg;
    localparam int N_CH  = 2;
    localparam int SEL_W = 3;

    // Register select codes. Channel c uses base 3*c for count, +1 reload, +2 enable.
    typedef enum logic [SEL_W-1:0] {
        SEL_RX_CNT  = 3'd0,
        SEL_RX_RLD  = 3'd1,
        SEL_RX_EN   = 3'd2,
        SEL_TX_CNT  = 3'd3,
        SEL_TX_RLD  = 3'd4,
        SEL_TX_EN   = 3'd5,
        SEL_FIN_CLR = 3'd6,
        SEL_STALL   = 3'd7
    } reg_sel_e;

    localparam int SEL_STRIDE = 3;
endpackage

// File: rtl/spi_wc_channel.sv
// One word counter channel: count register, reload register, enable bit
// and sticky finish flag.
// Assumes: write strobes are already decoded and one-hot per channel.
// A count write has priority over a decrement. A decrement from 1 loads
// the reload value directly, and a reload of 0 parks the count at 0.
module spi_wc_channel #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_wr,
    input  logic             rld_wr,
    input  logic             en_wr,
    input  logic             fin_clr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             word_done,
    output logic [CNT_W-1:0] count,
    output logic             finish
);
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] ZERO = '0;

    logic             en_q;
    logic [CNT_W-1:0] rld_q;
    logic [CNT_W-1:0] cnt_q;
    logic             fin_q;
    logic             step;
    logic             last_step;

    // A decrement happens only when enabled, pulsed, nonzero and not overwritten.
    assign step      = en_q && word_done && !cnt_wr && (cnt_q != ZERO);
    assign last_step = step && (cnt_q == ONE);

    // Enable bit, written from data bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n)      en_q <= 1'b0;
        else if (en_wr)  en_q <= wr_data[0];
    end

    // Reload value, writable only while the counter is disabled.
    always_ff @(posedge clk) begin
        if (!rst_n)                  rld_q <= ZERO;
        else if (rld_wr && !en_q)    rld_q <= wr_data;
    end

    // Word count: write, else decrement or reload at the end of a burst.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt_q <= ZERO;
        else if (cnt_wr)     cnt_q <= wr_data;
        else if (last_step)  cnt_q <= rld_q;
        else if (step)       cnt_q <= cnt_q - ONE;
    end

    // Sticky finish flag: set on the last decrement, cleared by write-one, set wins.
    always_ff @(posedge clk) begin
        if (!rst_n)          fin_q <= 1'b0;
        else if (last_step)  fin_q <= 1'b1;
        else if (fin_clr)    fin_q <= 1'b0;
    end

    assign count  = cnt_q;
    assign finish = fin_q;

    // R3: a disabled counter with no write holds its value
    p_hold_when_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && !cnt_wr) |=> $stable(count));

    // R5: a pulse at zero never wraps
    p_no_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && word_done && !cnt_wr && count == ZERO) |=> (count == ZERO));

    // R6: reload value is frozen while the counter runs
    p_reload_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        en_q |=> $stable(rld_q));

    // R7: the last decrement raises the finish flag at the same edge
    p_finish_on_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && word_done && !cnt_wr && count == ONE) |=> finish);

    // R7: the flag stays up without a clear
    p_finish_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (finish && !fin_clr) |=> finish);
endmodule

// File: rtl/spi_wc_stall.sv
// Transmit underflow stall: holds the stall option bit and gates it with
// the transmit FIFO empty status.
// Assumes: tx_fifo_empty is synchronous to clk. The output is combinational
// from it so the shift engine sees the stall in the cycle the FIFO empties.
module spi_wc_stall (
    input  logic clk,
    input  logic rst_n,
    input  logic opt_wr,
    input  logic opt_bit,
    input  logic fifo_empty,
    output logic stall
);
    logic opt_q;

    // Stall option bit, written through its own select.
    always_ff @(posedge clk) begin
        if (!rst_n)       opt_q <= 1'b0;
        else if (opt_wr)  opt_q <= opt_bit;
    end

    assign stall = opt_q & fifo_empty;

    // R9: a stall is never asserted while data is waiting
    p_stall_needs_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> fifo_empty);
endmodule

// File: rtl/spi_word_count_ctl.sv
// Transfer-length control for the receive and transmit channels of a SPI master.
// Decodes register writes into per-channel strobes, instantiates one counter
// per channel and the transmit stall gate.
// Assumes: wr_sel codes come from spi_wc_pkg, and word_done inputs are
// single-cycle pulses from the shift engine.
module spi_word_count_ctl
    import spi_wc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [SEL_W-1:0]      wr_sel,
    input  logic [CNT_W-1:0]      wr_data,
    input  logic                  rx_word_done,
    input  logic                  tx_word_done,
    input  logic                  tx_fifo_empty,
    output logic [CNT_W-1:0]      rx_count,
    output logic [CNT_W-1:0]      tx_count,
    output logic                  rx_finish,
    output logic                  tx_finish,
    output logic                  tx_stall
);
    logic [N_CH-1:0]  done_v;
    logic [N_CH-1:0]  fin_v;
    logic [CNT_W-1:0] cnt_v [N_CH];
    logic             clr_sel;

    assign done_v  = {tx_word_done, rx_word_done};
    assign clr_sel = wr_en && (wr_sel == SEL_FIN_CLR);

    // One counter channel per index, each decoding its own block of selects.
    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        logic cnt_wr_c;
        logic rld_wr_c;
        logic en_wr_c;
        logic clr_c;

        // Per-channel strobes from the shared select.
        assign cnt_wr_c = wr_en && (wr_sel == SEL_W'(SEL_STRIDE * c));
        assign rld_wr_c = wr_en && (wr_sel == SEL_W'(SEL_STRIDE * c + 1));
        assign en_wr_c  = wr_en && (wr_sel == SEL_W'(SEL_STRIDE * c + 2));
        assign clr_c    = clr_sel && wr_data[c];

        spi_wc_channel #(.CNT_W(CNT_W)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .cnt_wr    (cnt_wr_c),
            .rld_wr    (rld_wr_c),
            .en_wr     (en_wr_c),
            .fin_clr   (clr_c),
            .wr_data   (wr_data),
            .word_done (done_v[c]),
            .count     (cnt_v[c]),
            .finish    (fin_v[c])
        );
    end

    spi_wc_stall u_stall (
        .clk        (clk),
        .rst_n      (rst_n),
        .opt_wr     (wr_en && (wr_sel == SEL_STALL)),
        .opt_bit    (wr_data[0]),
        .fifo_empty (tx_fifo_empty),
        .stall      (tx_stall)
    );

    assign rx_count  = cnt_v[0];
    assign tx_count  = cnt_v[1];
    assign rx_finish = fin_v[0];
    assign tx_finish = fin_v[1];

    // R10: receive count is untouched by cycles with no receive activity
    p_rx_isolated_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_word_done && !wr_en) |=> $stable(rx_count));

    // R8: a clear write with bit 0 low leaves the receive flag as it was
    p_clear_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_sel && !wr_data[0] && rx_finish) |=> rx_finish);
endmodule

// File: tb/spi_word_count_ctl_bench.sv
module spi_word_count_ctl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [15:0] wr_data = '0;
    logic        rx_word_done = 1'b0;
    logic        tx_word_done = 1'b0;
    logic        tx_fifo_empty = 1'b0;
    logic [15:0] rx_count;
    logic [15:0] tx_count;
    logic        rx_finish;
    logic        tx_finish;
    logic        tx_stall;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    spi_word_count_ctl u_spi_word_count_ctl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rx_word_done(rx_word_done), .tx_word_done(tx_word_done),
        .tx_fifo_empty(tx_fifo_empty), .rx_count(rx_count), .tx_count(tx_count),
        .rx_finish(rx_finish), .tx_finish(tx_finish), .tx_stall(tx_stall)
    );

    typedef struct packed {
        logic        we;
        logic [2:0]  sel;
        logic [15:0] dat;
        logic        rxd;
        logic        txd;
        logic        fe;
        logic [15:0] erx;
        logic [15:0] etx;
        logic        erf;
        logic        etf;
        logic        est;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 3'd1, 16'd3, 1'b0, 1'b0, 1'b0, 16'd0, 16'd0, 1'b0, 1'b0, 1'b0, 8'd6},  // R6 reload while off
        '{1'b1, 3'd0, 16'd2, 1'b0, 1'b0, 1'b0, 16'd2, 16'd0, 1'b0, 1'b0, 1'b0, 8'd2},  // R2 count write
        '{1'b0, 3'd0, 16'd0, 1'b1, 1'b0, 1'b0, 16'd2, 16'd0, 1'b0, 1'b0, 1'b0, 8'd3},  // R3 disabled holds
        '{1'b1, 3'd2, 16'd1, 1'b0, 1'b0, 1'b0, 16'd2, 16'd0, 1'b0, 1'b0, 1'b0, 8'd3},  // R3 enable
        '{1'b0, 3'd0, 16'd0, 1'b1, 1'b0, 1'b0, 16'd1, 16'd0, 1'b0, 1'b0, 1'b0, 8'd3},  // R3 decrement
        '{1'b1, 3'd1, 16'd9, 1'b0, 1'b0, 1'b0, 16'd1, 16'd0, 1'b0, 1'b0, 1'b0, 8'd6},  // R6 ignored write
        '{1'b0, 3'd0, 16'd0, 1'b1, 1'b0, 1'b0, 16'd3, 16'd0, 1'b1, 1'b0, 1'b0, 8'd4},  // R4 reload, R7 flag
        '{1'b1, 3'd6, 16'd0, 1'b0, 1'b0, 1'b0, 16'd3, 16'd0, 1'b1, 1'b0, 1'b0, 8'd8},  // R8 zero bit
        '{1'b1, 3'd6, 16'd1, 1'b0, 1'b0, 1'b0, 16'd3, 16'd0, 1'b0, 1'b0, 1'b0, 8'd8},  // R8 clear
        '{1'b1, 3'd3, 16'd1, 1'b0, 1'b0, 1'b0, 16'd3, 16'd1, 1'b0, 1'b0, 1'b0, 8'd10}, // R10 tx write
        '{1'b1, 3'd5, 16'd1, 1'b0, 1'b0, 1'b0, 16'd3, 16'd1, 1'b0, 1'b0, 1'b0, 8'd3},  // R3 tx enable
        '{1'b0, 3'd0, 16'd0, 1'b0, 1'b1, 1'b0, 16'd3, 16'd0, 1'b0, 1'b1, 1'b0, 8'd5},  // R5 zero reload
        '{1'b0, 3'd0, 16'd0, 1'b1, 1'b1, 1'b0, 16'd2, 16'd0, 1'b0, 1'b1, 1'b0, 8'd5},  // R5 no wrap
        '{1'b0, 3'd0, 16'd0, 1'b0, 1'b0, 1'b1, 16'd2, 16'd0, 1'b0, 1'b1, 1'b0, 8'd9},  // R9 option off
        '{1'b1, 3'd7, 16'd1, 1'b0, 1'b0, 1'b1, 16'd2, 16'd0, 1'b0, 1'b1, 1'b1, 8'd9},  // R9 stall on
        '{1'b0, 3'd0, 16'd0, 1'b0, 1'b0, 1'b0, 16'd2, 16'd0, 1'b0, 1'b1, 1'b0, 8'd9},  // R9 not empty
        '{1'b1, 3'd6, 16'd2, 1'b0, 1'b0, 1'b1, 16'd2, 16'd0, 1'b0, 1'b0, 1'b1, 8'd8}   // R8 tx clear
    };

    task automatic drive(input logic we, input logic [2:0] sel, input logic [15:0] dat,
                         input logic rxd, input logic txd, input logic fe);
        @(negedge clk);
        wr_en = we; wr_sel = sel; wr_data = dat;
        rx_word_done = rxd; tx_word_done = txd; tx_fifo_empty = fe;
        @(posedge clk);
        #2;
    endtask

    task automatic idle();
        drive(1'b0, 3'd0, 16'd0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic chk(input string tag, input logic [15:0] erx, input logic [15:0] etx,
                       input logic erf, input logic etf, input logic est);
        n_run++;
        if (rx_count !== erx || tx_count !== etx || rx_finish !== erf ||
            tx_finish !== etf || tx_stall !== est) begin
            n_fail++;
            $display("FAIL %s: got rx=%0d tx=%0d rf=%0b tf=%0b st=%0b, expected rx=%0d tx=%0d rf=%0b tf=%0b st=%0b",
                     tag, rx_count, tx_count, rx_finish, tx_finish, tx_stall,
                     erx, etx, erf, etf, est);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2;
        chk("R1 in reset", 16'd0, 16'd0, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i].we, VEC[i].sel, VEC[i].dat, VEC[i].rxd, VEC[i].txd, VEC[i].fe);
            chk($sformatf("vector %0d R%0d", i, VEC[i].req),
                VEC[i].erx, VEC[i].etx, VEC[i].erf, VEC[i].etf, VEC[i].est);
        end

        // R2: a count write beats a word pulse in the same cycle
        drive(1'b1, 3'd0, 16'd5, 1'b1, 1'b0, 1'b0);
        chk("R2 write priority", 16'd5, 16'd0, 1'b0, 1'b0, 1'b0);

        // R7: a set and a clear in one cycle leave the flag set
        drive(1'b1, 3'd3, 16'd1, 1'b0, 1'b0, 1'b0);
        drive(1'b1, 3'd6, 16'd2, 1'b0, 1'b1, 1'b0);
        chk("R7 set wins", 16'd5, 16'd0, 1'b0, 1'b1, 1'b0);

        // R6: after disabling, a new reload value is taken and used
        drive(1'b1, 3'd2, 16'd0, 1'b0, 1'b0, 1'b0);
        drive(1'b1, 3'd1, 16'd4, 1'b0, 1'b0, 1'b0);
        drive(1'b1, 3'd2, 16'd1, 1'b0, 1'b0, 1'b0);
        drive(1'b1, 3'd0, 16'd1, 1'b0, 1'b0, 1'b0);
        drive(1'b0, 3'd0, 16'd0, 1'b1, 1'b0, 1'b0);
        chk("R6 new reload used", 16'd4, 16'd0, 1'b1, 1'b1, 1'b0);

        // R4: a second burst counts down from the reload value
        drive(1'b0, 3'd0, 16'd0, 1'b1, 1'b0, 1'b0);
        chk("R4 next burst", 16'd3, 16'd0, 1'b1, 1'b1, 1'b0);

        // R1: reset mid-run clears everything, including the stall option
        @(negedge clk);
        rst_n = 1'b0;
        tx_fifo_empty = 1'b1;
        @(posedge clk);
        #2;
        chk("R1 reset mid-run", 16'd0, 16'd0, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        tx_fifo_empty = 1'b0;

        // R1: after reset the enables are off, so pulses do nothing
        drive(1'b1, 3'd0, 16'd7, 1'b0, 1'b0, 1'b1);
        drive(1'b0, 3'd0, 16'd0, 1'b1, 1'b1, 1'b1);
        chk("R1 enable cleared", 16'd7, 16'd0, 1'b0, 1'b0, 1'b0);
        idle();

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule